// File: doc/BRIEF.md
# General-Purpose Event Status Logic

This block collects wake-up style events for a card socket controller and turns them into one event request line. Five general-purpose input pins are synchronized and watched for a level change in either direction. Two request fields coming from the socket control logic are also watched: the supply and programming voltage request, and separately, whether the programming voltage request moves onto or off the 12 V setting. Each detected event sets a sticky status bit.

Software reads the status byte and the enable byte through a small byte-wide register port (address, write strobe, write data, combinational read data). It clears status bits by writing ones to them. The event output is high whenever any status bit is set together with its enable bit. Only the global reset clears the registers. The reset is asynchronous on assertion and synchronized on release inside the block. The detectors prime themselves after reset, so pins that already sit at a non-zero level do not produce spurious events.

Top module: `gpe_status_unit`

## Requirements
- R1: After global reset both registers read 00h and `gpe_out` is low, and input levels already present during reset raise no status bit.
- R2: Address 88h reads the status byte, address 89h reads the enable byte, and any other address reads 00h.
- R3: A level change in either direction on `gpi_pin[n]` (n = 0..4) sets status bit n within four clock cycles, when `gpi_mode[n]` is 1.
- R4: When `gpi_mode[n]` is 0, changes on `gpi_pin[n]` leave status bit n at 0.
- R5: Any change of the concatenated request `{vcc_req, vpp_req}` sets status bit 7, and driving an unchanged value sets nothing.
- R6: Status bit 6 is set only when `vpp_req` moves to or from the code 2'b10 (12 V). Other `vpp_req` changes set bit 7 only.
- R7: Bit 5 of both registers always reads 0, and writes to it have no effect.
- R8: Writing status (88h) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: An event that arrives in the same clock cycle as a clear of its bit leaves that bit set.
- R10: Enable bits 7, 6 and 4..0 are read/write through address 89h.
- R11: `gpe_out` is high exactly when some status bit and the matching enable bit are both 1. It follows a register update with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| glb_rst_n | input | 1 | Global reset, active low, asynchronous assert |
| gpi_pin | input | 5 | Raw general-purpose input pins |
| gpi_mode | input | 5 | 1 = pin is used as a general-purpose input |
| vcc_req | input | 2 | Latched supply voltage request field |
| vpp_req | input | 2 | Latched programming voltage request field (2'b10 = 12 V) |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| gpe_out | output | 1 | Event request, any enabled status bit set |

## Verification
The hardest case to reach is the collision of a status clear with a new event for the same bit in one cycle. A pin change cannot line up with a given write, because it first passes through a synchronizer. The request fields, however, are compared against their registered copies on the very edge that samples them. So the bench drives a new `vcc_req` value and a one-to-clear write on the same falling edge, and both are taken on the following rising edge. The reset-priming case is reached by holding non-zero pins and requests through and past reset release.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int BYTE_W    = 8;
  localparam int N_GPI     = 5;
  localparam int BIT_RSVD  = 5;
  localparam int BIT_VPP12 = 6;
  localparam int BIT_PWR   = 7;
  localparam logic [BYTE_W-1:0] WRITABLE_MASK = ~(8'h01 << BIT_RSVD);
  typedef logic [BYTE_W-1:0] gpe_byte_t;
endpackage

// File: rtl/gpe_sync_detect.sv
module gpe_sync_detect #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] sel,
  output logic [N-1:0] ev
);
  localparam int ARM_W = STAGES + 1;

  logic [STAGES-1:0][N-1:0] stg_q, stg_d;
  logic [N-1:0]             prev_q, prev_d;
  logic [ARM_W-1:0]         arm_q, arm_d;
  logic [N-1:0]             settled;

  always_comb begin
    stg_d[0] = pin;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  assign settled = stg_q[STAGES-1];
  assign prev_d  = settled;
  assign arm_d   = {arm_q[ARM_W-2:0], 1'b1};
  assign ev      = (settled ^ prev_q) & sel & {N{arm_q[ARM_W-1]}};

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      prev_q <= prev_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/gpe_pwr_detect.sv
module gpe_pwr_detect #(
  parameter int              VCC_W   = 2,
  parameter int              VPP_W   = 2,
  parameter logic [VPP_W-1:0] VPP_HI = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VCC_W-1:0] vcc_req,
  input  logic [VPP_W-1:0] vpp_req,
  output logic             ev_pwr,
  output logic             ev_hi
);
  logic [VCC_W-1:0] vcc_prev_q;
  logic [VPP_W-1:0] vpp_prev_q;
  logic             armed_q;
  logic             hi_now, hi_prev;

  assign hi_now  = (vpp_req == VPP_HI);
  assign hi_prev = (vpp_prev_q == VPP_HI);
  assign ev_pwr  = armed_q && ({vcc_req, vpp_req} != {vcc_prev_q, vpp_prev_q});
  assign ev_hi   = armed_q && (hi_now != hi_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_prev_q <= '0;
      vpp_prev_q <= '0;
      armed_q    <= 1'b0;
    end else begin
      vcc_prev_q <= vcc_req;
      vpp_prev_q <= vpp_req;
      armed_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/gpe_regs.sv
module gpe_regs
  import gpe_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h88,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h89
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  gpe_byte_t         reg_wdata,
  input  gpe_byte_t         ev_vec,
  output gpe_byte_t         sts_q,
  output gpe_byte_t         en_q,
  output gpe_byte_t         reg_rdata,
  output logic              wr_sts,
  output logic              wr_en
);
  gpe_byte_t sts_d, en_d, clr;
  logic      sts_ce, en_ce;

  assign wr_sts = reg_wr && (reg_addr == STS_ADDR);
  assign wr_en  = reg_wr && (reg_addr == EN_ADDR);
  assign clr    = wr_sts ? reg_wdata : '0;

  always_comb begin
    sts_d  = ((sts_q & ~clr) | ev_vec) & WRITABLE_MASK;
    sts_ce = wr_sts || (ev_vec != '0);
    en_d   = reg_wdata & WRITABLE_MASK;
    en_ce  = wr_en;
  end

  always_comb begin
    if (reg_addr == STS_ADDR)     reg_rdata = sts_q;
    else if (reg_addr == EN_ADDR) reg_rdata = en_q;
    else                          reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/gpe_status_unit.sv
module gpe_status_unit
  import gpe_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter int                 VCC_W       = 2,
  parameter int                 VPP_W       = 2,
  parameter logic [VPP_W-1:0]   VPP_HI      = 2'b10,
  parameter int                 ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]  STS_ADDR    = 8'h88,
  parameter logic [ADDR_W-1:0]  EN_ADDR     = 8'h89
) (
  input  logic              clk,
  input  logic              glb_rst_n,
  input  logic [N_GPI-1:0]  gpi_pin,
  input  logic [N_GPI-1:0]  gpi_mode,
  input  logic [VCC_W-1:0]  vcc_req,
  input  logic [VPP_W-1:0]  vpp_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              gpe_out
);
  logic [1:0]       rst_pipe_q;
  logic             rst_n;
  logic [N_GPI-1:0] ev_gpi;
  logic             ev_pwr, ev_hi;
  gpe_byte_t        ev_vec, sts_q, en_q;
  logic             wr_sts, wr_en;

  always_ff @(posedge clk or negedge glb_rst_n) begin
    if (!glb_rst_n) rst_pipe_q <= 2'b00;
    else            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  gpe_sync_detect #(.N(N_GPI), .STAGES(SYNC_STAGES)) u_gpi (
    .clk(clk), .rst_n(rst_n), .pin(gpi_pin), .sel(gpi_mode), .ev(ev_gpi)
  );

  gpe_pwr_detect #(.VCC_W(VCC_W), .VPP_W(VPP_W), .VPP_HI(VPP_HI)) u_pwr (
    .clk(clk), .rst_n(rst_n), .vcc_req(vcc_req), .vpp_req(vpp_req),
    .ev_pwr(ev_pwr), .ev_hi(ev_hi)
  );

  always_comb begin
    ev_vec                = '0;
    ev_vec[N_GPI-1:0]     = ev_gpi;
    ev_vec[BIT_VPP12]     = ev_hi;
    ev_vec[BIT_PWR]       = ev_pwr;
  end

  gpe_regs #(.ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .EN_ADDR(EN_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev_vec(ev_vec), .sts_q(sts_q), .en_q(en_q),
    .reg_rdata(reg_rdata), .wr_sts(wr_sts), .wr_en(wr_en)
  );

  assign gpe_out = |(sts_q & en_q);
endmodule

module gpe_status_chk
  import gpe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_sts,
  input logic             wr_en,
  input gpe_byte_t        reg_wdata,
  input logic [N_GPI-1:0] gpi_mode,
  input gpe_byte_t        ev_vec,
  input gpe_byte_t        sts_q,
  input gpe_byte_t        en_q,
  input logic             gpe_out
);
  // R3 / R9: every detected event is visible in status on the next cycle
  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) |=> ((sts_q & $past(ev_vec)) == $past(ev_vec)));

  // R8: set bits persist unless a clear write happens
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R8: bits written with 1 drop unless an event hit the same bit
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((sts_q & $past(reg_wdata) & ~$past(ev_vec)) == '0));

  // R10 / R7: enable register takes written data, bit 5 stays 0
  p_enable_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == ($past(reg_wdata) & WRITABLE_MASK)));

  // R11: with nothing enabled the event line stays low
  p_gpe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !gpe_out);

  // R4: deselected pins never report events
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_vec[N_GPI-1:0] & ~gpi_mode) == '0));
endmodule

bind gpe_status_unit gpe_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wr_en(wr_en),
  .reg_wdata(reg_wdata), .gpi_mode(gpi_mode), .ev_vec(ev_vec),
  .sts_q(sts_q), .en_q(en_q), .gpe_out(gpe_out)
);

// File: tb/test_gpe_status_unit.sv
module test_gpe_status_unit;
  logic       clk = 1'b0;
  logic       glb_rst_n;
  logic [4:0] gpi_pin, gpi_mode;
  logic [1:0] vcc_req, vpp_req;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, gpe_out;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  gpe_status_unit i_gpe_status_unit (
    .clk(clk), .glb_rst_n(glb_rst_n), .gpi_pin(gpi_pin), .gpi_mode(gpi_mode),
    .vcc_req(vcc_req), .vpp_req(vpp_req), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpe_out(gpe_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    glb_rst_n = 1'b0;
    gpi_pin = 5'b10101; gpi_mode = 5'h1F; vcc_req = 2'b01; vpp_req = 2'b10;
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    idle(3);
    glb_rst_n = 1'b1;
    idle(10);
    rd(8'h88, v); check("R1 status after reset", v, 8'h00);
    rd(8'h89, v); check("R1 enable after reset", v, 8'h00);
    check("R1 gpe after reset", {7'd0, gpe_out}, 8'h00);
  endtask

  task automatic t_addr;
    logic [7:0] v;
    wr(8'h89, 8'hFF);
    rd(8'h89, v); check("R10 R7 enable all ones", v, 8'hDF);
    wr(8'h89, 8'h5A);
    rd(8'h89, v); check("R10 enable pattern", v, 8'h5A);
    rd(8'h42, v); check("R2 unmapped address", v, 8'h00);
    wr(8'h89, 8'h00);
    wr(8'h88, 8'h20);
    rd(8'h88, v); check("R7 status reserved write", v, 8'h00);
  endtask

  task automatic t_gpi;
    logic [7:0] v;
    @(negedge clk) gpi_pin[1] = ~gpi_pin[1];
    idle(4);
    rd(8'h88, v); check("R3 pin1 change", v, 8'h02);
    wr(8'h88, 8'h02);
    rd(8'h88, v); check("R8 clear pin1", v, 8'h00);
    @(negedge clk) gpi_pin[1] = ~gpi_pin[1];
    idle(4);
    rd(8'h88, v); check("R3 pin1 reverse edge", v, 8'h02);
    wr(8'h88, 8'hFF);
    @(negedge clk) gpi_pin[4] = ~gpi_pin[4];
    idle(4);
    rd(8'h88, v); check("R3 pin4 change", v, 8'h10);
    wr(8'h88, 8'h10);
  endtask

  task automatic t_mode;
    logic [7:0] v;
    gpi_mode = 5'h1E;
    @(negedge clk) gpi_pin[0] = ~gpi_pin[0];
    idle(5);
    rd(8'h88, v); check("R4 deselected pin0", v, 8'h00);
    gpi_mode = 5'h1F;
    idle(2);
  endtask

  task automatic t_pwr;
    logic [7:0] v;
    @(negedge clk) vcc_req = 2'b11;
    idle(2);
    rd(8'h88, v); check("R5 supply change", v, 8'h80);
    wr(8'h88, 8'h80);
    @(negedge clk) vcc_req = 2'b11;
    idle(2);
    rd(8'h88, v); check("R5 unchanged value", v, 8'h00);
    @(negedge clk) vpp_req = 2'b01;
    idle(2);
    rd(8'h88, v); check("R6 leave 12V", v, 8'hC0);
    wr(8'h88, 8'hC0);
    @(negedge clk) vpp_req = 2'b00;
    idle(2);
    rd(8'h88, v); check("R6 non 12V change", v, 8'h80);
    wr(8'h88, 8'h80);
    @(negedge clk) vpp_req = 2'b10;
    idle(2);
    rd(8'h88, v); check("R6 enter 12V", v, 8'hC0);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    wr(8'h88, 8'h40);
    rd(8'h88, v); check("R8 partial clear", v, 8'h80);
    wr(8'h88, 8'h00);
    rd(8'h88, v); check("R8 zero write", v, 8'h80);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    @(negedge clk);
    vcc_req = 2'b01;
    reg_addr = 8'h88; reg_wdata = 8'h80; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(8'h88, v); check("R9 event beats clear", v, 8'h80);
    wr(8'h88, 8'h80);
    rd(8'h88, v); check("R8 clear after collision", v, 8'h00);
  endtask

  task automatic t_gpe;
    logic [7:0] v;
    wr(8'h88, 8'h80);
    @(negedge clk) vcc_req = 2'b10;
    idle(2);
    wr(8'h89, 8'h01);
    #1 check("R11 masked status", {7'd0, gpe_out}, 8'h00);
    @(negedge clk) gpi_pin[0] = ~gpi_pin[0];
    idle(4);
    #1 check("R11 enabled pin0", {7'd0, gpe_out}, 8'h01);
    @(negedge clk);
    reg_addr = 8'h89; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(posedge clk); #1;
    check("R11 same-cycle disable", {7'd0, gpe_out}, 8'h00);
    @(negedge clk) reg_wr = 1'b0;
    wr(8'h89, 8'h80);
    #1 check("R11 enable power bit", {7'd0, gpe_out}, 8'h01);
    glb_rst_n = 1'b0;
    idle(2);
    glb_rst_n = 1'b1;
    idle(10);
    rd(8'h88, v); check("R1 global reset clears", v, 8'h00);
    check("R1 gpe low after reset", {7'd0, gpe_out}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_addr();
    t_gpi();
    t_mode();
    t_pwr();
    t_w1c();
    t_collide();
    t_gpe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule